// File: doc/BRIEF.md
# Reference Frequency Monitor with Holdover Flag

This block judges the frequency of an incoming reference clock against a stable local clock. The reference is synchronized into the local domain and its rising edges are counted over a fixed gate window of `GATE_CYCLES` local cycles. At the end of each window the count is compared with two pairs of bounds that belong to the selected nominal reference frequency. A tight pair decides the frequency-limit flag. A loose pair, together with a missing-reference timer, decides the holdover flag.

A 2-bit select picks one of four nominal reference rates. Each code has its own count bounds, supplied as parameters, so the same logic serves any local clock and window length. Both flags and the select are also packed into an 8-bit status word for read-out.

Top module: `ref_freq_monitor`

## Requirements
- R1: `status` carries `freq_sel` in bits 4:3, `holdover` in bit 1 and `freq_limit` in bit 0. Bits 7:5 and bit 2 read as 0.
- R2: While `rst_n` is low, and until the first window end after release, `freq_limit` and `holdover` are 0.
- R3: At each window end, `freq_limit` becomes 1 exactly when the rising-edge count for that window lies outside the narrow bounds of the code on `freq_sel`. The code meanings are 00 = 19.44 MHz, 01 = 8 kHz, 10 = 1.544 MHz, 11 = 2.048 MHz.
- R4: At each window end, `holdover` becomes 1 when the count lies outside the wide bounds of the selected code.
- R5: If no synchronized rising edge arrives for `LOSS_CYCLES` local cycles at any point in a window, `holdover` is 1 after that window ends.
- R6: Once set, `holdover` clears only at the end of a full window in which the count was inside the wide bounds and no loss was seen. The window in which the reference returns keeps it set.
- R7: The two flags change only at a window end, which falls every `GATE_CYCLES` cycles after reset release.
- R8: A reference at its nominal rate for the selected code gives both flags 0.
- R9: The reference passes through a two-flop synchronizer, and each rising edge is counted once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stable local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to `clk` |
| freq_sel | input | 2 | Nominal reference code |
| freq_limit | output | 1 | Count outside narrow bounds in the last window |
| holdover | output | 1 | Count outside wide bounds, or reference lost |
| status | output | 8 | Packed flags and select for read-out |

## Verification
The hardest case to reach from the ports is the release of holdover. To reach it, the reference must come back part way through a window, and the flag must then be seen to stay set across that partial window and clear only one window later. The bench keeps its own count of cycles since reset release, which gives it the window phase. It stops the reference until holdover is set, restarts it mid-window, and samples the flag just after the next two window ends and just before the second one. The rest of the stimulus sweeps all four codes, each with a nominal period, slightly slow and slightly fast periods, grossly slow and grossly fast periods, and a stopped reference. The bench computes the possible counts from the periods, and skips any case where the count could fall on either side of a bound.

// File: rtl/ref_freq_monitor.sv
`timescale 1ps/1ps
module ref_freq_monitor #(
  parameter int unsigned GATE_CYCLES = 1000000,
  parameter int unsigned LOSS_CYCLES = 25000,
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned NARROW_LO [4] = '{194380, 79, 15438, 20478},
  parameter int unsigned NARROW_HI [4] = '{194420, 81, 15442, 20482},
  parameter int unsigned WIDE_LO   [4] = '{188568, 77, 14977, 19866},
  parameter int unsigned WIDE_HI   [4] = '{200232, 83, 15903, 21094}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic [1:0] freq_sel,
  output logic       freq_limit,
  output logic       holdover,
  output logic [7:0] status
);
  localparam int unsigned GW = $clog2(GATE_CYCLES + 1);
  localparam int unsigned LW = $clog2(LOSS_CYCLES + 1);
  localparam int unsigned MW = CNT_W + 1;

  logic [2:0]       sync_q;
  logic [GW-1:0]    gate_q;
  logic [CNT_W-1:0] edge_q;
  logic [LW-1:0]    idle_q;
  logic             lost_win_q;
  logic             ref_edge, win_end, ref_lost;
  logic [MW-1:0]    meas;
  logic             in_narrow, in_wide;

  assign ref_edge = sync_q[1] & ~sync_q[2];
  assign win_end  = (gate_q == GW'(GATE_CYCLES - 1));
  assign ref_lost = (idle_q == LW'(LOSS_CYCLES));
  assign meas     = {1'b0, edge_q} + MW'(ref_edge);

  assign in_narrow = (meas >= MW'(NARROW_LO[freq_sel])) && (meas <= MW'(NARROW_HI[freq_sel]));
  assign in_wide   = (meas >= MW'(WIDE_LO[freq_sel]))   && (meas <= MW'(WIDE_HI[freq_sel]));

  assign status = {3'b000, freq_sel, 1'b0, holdover, freq_limit};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ref_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       gate_q <= '0;
    else if (win_end) gate_q <= '0;
    else              gate_q <= gate_q + GW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          edge_q <= '0;
    else if (win_end)                    edge_q <= '0;
    else if (ref_edge && edge_q != '1)   edge_q <= edge_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         idle_q <= '0;
    else if (ref_edge)  idle_q <= '0;
    else if (!ref_lost) idle_q <= idle_q + LW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        lost_win_q <= 1'b0;
    else if (win_end)  lost_win_q <= 1'b0;
    else if (ref_lost) lost_win_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      freq_limit <= 1'b0;
      holdover   <= 1'b0;
    end else if (win_end) begin
      freq_limit <= !in_narrow;
      holdover   <= !in_wide || lost_win_q || ref_lost;
    end
endmodule

module ref_freq_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic win_end,
  input logic ref_edge,
  input logic ref_lost,
  input logic freq_limit,
  input logic holdover
);
  // R2
  always @(posedge clk)
    if (!rst_n) reset_flags_chk: assert (!freq_limit && !holdover);

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable({freq_limit, holdover}));

  // R5
  loss_forces_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && ref_lost) |=> holdover);

  // R6
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdover) |-> $past(win_end));

  // R9
  edge_clears_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_edge |=> !ref_lost);
endmodule

bind ref_freq_monitor ref_freq_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .win_end(win_end), .ref_edge(ref_edge),
  .ref_lost(ref_lost), .freq_limit(freq_limit), .holdover(holdover)
);

// File: tb/ref_freq_monitor_tb.sv
`timescale 1ps/1ps
module ref_freq_monitor_tb_top;
  localparam int G    = 800;
  localparam int LOSS = 64;
  localparam int CW   = 10;
  localparam int TCLK = 5000;
  localparam int WIN_PS = G * TCLK;
  localparam int unsigned NL [4] = '{198, 39, 99, 158};
  localparam int unsigned NH [4] = '{202, 41, 101, 162};
  localparam int unsigned WL [4] = '{180, 36, 90, 144};
  localparam int unsigned WH [4] = '{220, 44, 110, 176};
  localparam int NOM [4] = '{20000, 100000, 40000, 25000};

  logic clk = 0, rst_n = 0, ref_in = 0;
  logic [1:0] sel = 2'b01;
  logic freq_limit, holdover;
  logic [7:0] status;
  int per = 0;
  int cyc = 0;
  int n_chk = 0, n_bad = 0;

  ref_freq_monitor #(
    .GATE_CYCLES(G), .LOSS_CYCLES(LOSS), .CNT_W(CW),
    .NARROW_LO(NL), .NARROW_HI(NH), .WIDE_LO(WL), .WIDE_HI(WH)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .freq_sel(sel),
    .freq_limit(freq_limit), .holdover(holdover), .status(status)
  );

  always #(TCLK/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  initial begin
    #1234;
    forever begin
      if (per == 0) begin ref_in = 0; #1000; end
      else begin ref_in = 1; #(per/2); ref_in = 0; #(per - per/2); end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d (sel=%0d per=%0d)", req, act, exp, sel, per);
    end
  endtask

  function automatic int out_of(int p, int lo, int hi);
    int c0, c1;
    bit i0, i1;
    if (p == 0) begin c0 = 0; c1 = 0; end
    else begin c0 = WIN_PS / p; c1 = c0 + ((WIN_PS % p) != 0 ? 1 : 0); end
    i0 = (c0 >= lo) && (c0 <= hi);
    i1 = (c1 >= lo) && (c1 <= hi);
    if (i0 && i1) return 0;
    if (!i0 && !i1) return 1;
    return -1;
  endfunction

  task automatic check_status(string req);
    check(req, status, {3'b000, sel, 1'b0, holdover, freq_limit});
  endtask

  task automatic step(int code, int p, string tag);
    int el, eh;
    sel = code[1:0];
    per = p;
    repeat (3 * G) @(negedge clk);
    el = out_of(p, NL[code], NH[code]);
    eh = (p == 0) ? 1 : out_of(p, WL[code], WH[code]);
    if (el >= 0) check({tag, " R3 freq_limit"}, freq_limit, el);
    if (eh >= 0) check({tag, (p == 0) ? " R5 holdover" : " R4 holdover"}, holdover, eh);
    check_status({tag, " R1 status"});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R2 freq_limit in reset", freq_limit, 0);
    check("R2 holdover in reset", holdover, 0);
    check("R1 status in reset", status, 8'h08);
    rst_n = 1;
    repeat (G - 10) @(negedge clk);
    check("R2 flags before first window end", {freq_limit, holdover}, 0);

    for (int c = 0; c < 4; c++) begin
      step(c, NOM[c], "R8 nominal");
      step(c, NOM[c] * 106 / 100, "slow slight");
      step(c, NOM[c] * 94 / 100, "fast slight");
      step(c, NOM[c] * 3 / 2, "slow gross");
      step(c, NOM[c] * 7 / 10, "fast gross");
      step(c, 0, "stopped");
      step(c, NOM[c], "R8 R6 recovered");
    end

    sel = 2'b10;
    per = 0;
    repeat (3 * G) @(negedge clk);
    check("R5 holdover when stopped", holdover, 1);
    do @(negedge clk); while (cyc % G != G / 2);
    per = NOM[2];
    do @(negedge clk); while (cyc % G != 0);
    check("R6 holdover kept after partial window", holdover, 1);
    do @(negedge clk); while (cyc % G != G - 1);
    check("R7 holdover unchanged before window end", holdover, 1);
    @(negedge clk);
    check("R6 holdover cleared after clean window", holdover, 0);
    check("R9 freq_limit after clean window", freq_limit, 0);
    check_status("R1 status after recovery");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(180000 * TCLK);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule